// File: doc/BRIEF.md
# Receiver Control and Status Register Block

This block is the software-facing register file of a serial camera packet receiver. An AXI4-Lite slave port gives access to a small set of 32-bit words. They hold the receiver run/stop control, a hold-in-reset control, the number of active data lanes and an example pixel-mask configuration word. A status word shows two FIFO-full flags that arrive from the receiver's own clock domain. The block drives the enable, soft-reset and lane-shutdown signals that the receive datapath uses.

Only the low seven address bits are looked at, so the map repeats every 128 bytes. Byte strobes play no part: every accepted write replaces the whole word. While the hold-in-reset bit is set, the configuration word is forced back to its default. The run bit, the hold-in-reset bit itself and the lane count keep their values. Setting the run bit to 0 stops the receiver and shuts the lanes down. The hold-in-reset bit alone does not shut the lanes down.

Top module: `rxctl_regfile`

## Requirements
- R1: After aresetn, the control word at offset 0x00 reads 0x1, the lane word at 0x04 reads 0x3, and the mask word at 0x08 reads 0x000000FF. The outputs show core_en=1, soft_rst=0, lane_shutdown=0, active_lanes=3 and cfg_word=0x00FF, with awready, wready and arready high.
- R2: Address bits above bit 6 are ignored on both channels, so 0x88 reaches the same word as 0x08. Word offsets are taken from bits 6:2.
- R3: s_wstrb has no effect, and every accepted write replaces all 32 bits of the addressed word, even with a strobe of 0 or 1.
- R4: A write to an unmapped offset (any offset other than 0x00, 0x04, 0x08 and 0x10) returns OKAY and changes no register. A read of an unmapped offset returns OKAY with data 0.
- R5: Bits that no field uses read as 0. In the control word, bit 0 is run and bit 1 is hold-in-reset. The lane count is bits 1:0 of 0x04. The mask is bits 15:0 of 0x08.
- R6: While hold-in-reset is 1, the mask word returns to 0x00FF and writes to it are dropped. The run bit, the hold-in-reset bit and the lane count keep their values, and soft_rst is 1.
- R7: Writing 0 to hold-in-reset releases the block, and the mask word then accepts writes again.
- R8: lane_shutdown is 1 exactly when the run bit is 0. With run=1 and hold-in-reset=1, lane_shutdown stays 0.
- R9: Status word 0x10 is read-only. Bit 0 shows lbuf_full_async and bit 1 shows spkt_full_async, each through a two-flop synchroniser. A read issued in the same cycle that an input changes still returns the old value.
- R10: The write address and write data channels are accepted independently, in either order. s_bvalid rises only once both are taken, bresp is always OKAY, and no new write is accepted while a response is pending.
- R11: A read returns OKAY with data registered at the address handshake. While s_rvalid waits for s_rready, s_arready stays low and s_rdata holds steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Register clock |
| aresetn | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Byte strobes (ignored) |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| lbuf_full_async | input | 1 | Line-buffer-full flag from the receiver clock domain |
| spkt_full_async | input | 1 | Short-packet-FIFO-full flag from the receiver clock domain |
| core_en | output | 1 | Receiver run control |
| soft_rst | output | 1 | Receiver hold-in-reset control |
| lane_shutdown | output | 1 | Lane shutdown request |
| active_lanes | output | LANE_W | Number of active lanes setting |
| cfg_word | output | CFG_W | Pixel-mask configuration value |

## Verification
The hardest states to reach are those where the two write channels are out of step, and where a response is held back. Examples are data accepted several cycles before its address, and a second write offered while bvalid waits on a low bready. The bench drives the address and data channels from separate threads with chosen delays. It holds bready or rready low on purpose and watches the ready outputs and the held response in the cycles in between. It reaches the hold-in-reset state by writing a full word of ones to the control word. It then shows that the mask write is dropped, and that the lane word and lane_shutdown do not change.

// File: rtl/rxctl_pkg.sv
package rxctl_pkg;

  localparam int DEC_W = 7;
  localparam int WORD_LSB = 2;
  localparam int IDX_W = DEC_W - WORD_LSB;

  localparam logic [IDX_W-1:0] IDX_CTRL  = 5'd0;
  localparam logic [IDX_W-1:0] IDX_LANES = 5'd1;
  localparam logic [IDX_W-1:0] IDX_CFG   = 5'd2;
  localparam logic [IDX_W-1:0] IDX_STAT  = 5'd4;

  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [2:0] {
    SEL_CTRL,
    SEL_LANES,
    SEL_CFG,
    SEL_STAT,
    SEL_NONE
  } reg_sel_e;

  function automatic reg_sel_e decode_word(input logic [IDX_W-1:0] idx);
    reg_sel_e s;
    case (idx)
      IDX_CTRL:  s = SEL_CTRL;
      IDX_LANES: s = SEL_LANES;
      IDX_CFG:   s = SEL_CFG;
      IDX_STAT:  s = SEL_STAT;
      default:   s = SEL_NONE;
    endcase
    return s;
  endfunction

  function automatic logic writable(input reg_sel_e s, input logic held);
    return (s == SEL_CTRL) || (s == SEL_LANES) || ((s == SEL_CFG) && !held);
  endfunction

endpackage

// File: rtl/rxctl_wr_chan.sv
module rxctl_wr_chan #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  output logic              wr_fire,
  output logic [rxctl_pkg::DEC_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  import rxctl_pkg::*;

  logic              aw_got, w_got, bvalid_q;
  logic [DEC_W-1:0]  aw_q;
  logic [DATA_W-1:0] w_q;

  assign awready = !aw_got && !bvalid_q;
  assign wready  = !w_got && !bvalid_q;
  assign wr_fire = aw_got && w_got;
  assign wr_addr = aw_q;
  assign wr_data = w_q;
  assign bvalid  = bvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_got   <= 1'b0;
      w_got    <= 1'b0;
      bvalid_q <= 1'b0;
      aw_q     <= '0;
      w_q      <= '0;
    end else begin
      if (awvalid && awready) begin
        aw_got <= 1'b1;
        aw_q   <= awaddr[DEC_W-1:0];
      end
      if (wvalid && wready) begin
        w_got <= 1'b1;
        w_q   <= wdata;
      end
      if (wr_fire) begin
        aw_got   <= 1'b0;
        w_got    <= 1'b0;
        bvalid_q <= 1'b1;
      end else if (bvalid_q && bready) begin
        bvalid_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rxctl_rd_chan.sv
module rxctl_rd_chan #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  input  logic              rready,
  output logic              rd_fire,
  output logic [rxctl_pkg::DEC_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_word
);
  import rxctl_pkg::*;

  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign arready = !rvalid_q;
  assign rd_fire = arvalid && arready;
  assign rd_addr = araddr[DEC_W-1:0];
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_fire) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_word;
    end else if (rvalid_q && rready) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rxctl_sync.sv
module rxctl_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_async[b]};
    end
    assign q_sync[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/rxctl_regs.sv
module rxctl_regs #(
  parameter int DATA_W   = 32,
  parameter int LANE_W   = 2,
  parameter int LANE_RST = 3,
  parameter int CFG_W    = 16,
  parameter int CFG_RST  = 'h00FF,
  parameter int N_STAT   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_fire,
  input  logic [rxctl_pkg::DEC_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [rxctl_pkg::DEC_W-1:0] rd_addr,
  output logic [DATA_W-1:0]           rd_word,
  input  logic [N_STAT-1:0]           stat_sync,
  output logic                        run_q,
  output logic                        hold_q,
  output logic [LANE_W-1:0]           lanes_q,
  output logic [CFG_W-1:0]            cfg_q,
  output rxctl_pkg::reg_sel_e         wr_sel
);
  import rxctl_pkg::*;

  localparam logic [LANE_W-1:0] LANE_DEF = LANE_W'(LANE_RST);
  localparam logic [CFG_W-1:0]  CFG_DEF  = CFG_W'(CFG_RST);

  reg_sel_e rd_sel;
  logic     wr_ok;

  assign wr_sel = decode_word(wr_addr[DEC_W-1:WORD_LSB]);
  assign rd_sel = decode_word(rd_addr[DEC_W-1:WORD_LSB]);
  assign wr_ok  = wr_fire && writable(wr_sel, hold_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b1;
      hold_q  <= 1'b0;
      lanes_q <= LANE_DEF;
    end else if (wr_ok) begin
      if (wr_sel == SEL_CTRL) begin
        run_q  <= wr_data[0];
        hold_q <= wr_data[1];
      end
      if (wr_sel == SEL_LANES) lanes_q <= wr_data[LANE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            cfg_q <= CFG_DEF;
    else if (hold_q)                       cfg_q <= CFG_DEF;
    else if (wr_ok && wr_sel == SEL_CFG)   cfg_q <= wr_data[CFG_W-1:0];
  end

  always_comb begin
    rd_word = '0;
    case (rd_sel)
      SEL_CTRL:  rd_word = {{(DATA_W-2){1'b0}}, hold_q, run_q};
      SEL_LANES: rd_word = {{(DATA_W-LANE_W){1'b0}}, lanes_q};
      SEL_CFG:   rd_word = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
      SEL_STAT:  rd_word = {{(DATA_W-N_STAT){1'b0}}, stat_sync};
      default:   rd_word = '0;
    endcase
  end
endmodule

// File: rtl/rxctl_regfile.sv
module rxctl_regfile #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LANE_W   = 2,
  parameter int LANE_RST = 3,
  parameter int CFG_W    = 16,
  parameter int CFG_RST  = 'h00FF,
  parameter int SYNC_N   = 2
) (
  input  logic                aclk,
  input  logic                aresetn,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  input  logic [ADDR_W-1:0]   s_araddr,
  input  logic                s_arvalid,
  output logic                s_arready,
  output logic [DATA_W-1:0]   s_rdata,
  output logic [1:0]          s_rresp,
  output logic                s_rvalid,
  input  logic                s_rready,
  input  logic                lbuf_full_async,
  input  logic                spkt_full_async,
  output logic                core_en,
  output logic                soft_rst,
  output logic                lane_shutdown,
  output logic [LANE_W-1:0]   active_lanes,
  output logic [CFG_W-1:0]    cfg_word
);
  import rxctl_pkg::*;

  localparam int N_STAT = 2;

  // Named internal events, observed by the bound checker.
  logic                wr_fire, rd_fire;
  logic [DEC_W-1:0]    wr_addr, rd_addr;
  logic [DATA_W-1:0]   wr_data, rd_word;
  logic [N_STAT-1:0]   stat_sync;
  logic                run_q, hold_q;
  reg_sel_e            wr_sel;

  rxctl_wr_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk(aclk), .rst_n(aresetn),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  rxctl_rd_chan #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(aclk), .rst_n(aresetn),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
    .rd_fire(rd_fire), .rd_addr(rd_addr), .rd_word(rd_word)
  );

  rxctl_sync #(.WIDTH(N_STAT), .STAGES(SYNC_N)) u_sync (
    .clk(aclk), .rst_n(aresetn),
    .d_async({spkt_full_async, lbuf_full_async}),
    .q_sync(stat_sync)
  );

  rxctl_regs #(
    .DATA_W(DATA_W), .LANE_W(LANE_W), .LANE_RST(LANE_RST),
    .CFG_W(CFG_W), .CFG_RST(CFG_RST), .N_STAT(N_STAT)
  ) u_regs (
    .clk(aclk), .rst_n(aresetn),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_word(rd_word),
    .stat_sync(stat_sync),
    .run_q(run_q), .hold_q(hold_q), .lanes_q(active_lanes), .cfg_q(cfg_word),
    .wr_sel(wr_sel)
  );

  assign s_bresp       = RESP_OKAY;
  assign s_rresp       = RESP_OKAY;
  assign core_en       = run_q;
  assign soft_rst      = hold_q;
  assign lane_shutdown = !run_q;
endmodule

// File: rtl/rxctl_regfile_chk.sv
module rxctl_regfile_chk #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int LANE_W   = 2,
  parameter int CFG_W    = 16,
  parameter int CFG_RST  = 'h00FF
) (
  input logic                aclk,
  input logic                aresetn,
  input logic [ADDR_W-1:0]   s_awaddr,
  input logic                s_awvalid,
  input logic                s_awready,
  input logic [DATA_W/8-1:0] s_wstrb,
  input logic                s_wvalid,
  input logic                s_wready,
  input logic [1:0]          s_bresp,
  input logic                s_bvalid,
  input logic                s_bready,
  input logic [ADDR_W-1:0]   s_araddr,
  input logic                s_arvalid,
  input logic                s_arready,
  input logic [DATA_W-1:0]   s_rdata,
  input logic [1:0]          s_rresp,
  input logic                s_rvalid,
  input logic                s_rready,
  input logic                lbuf_full_async,
  input logic                core_en,
  input logic                soft_rst,
  input logic                lane_shutdown,
  input logic [LANE_W-1:0]   active_lanes,
  input logic [CFG_W-1:0]    cfg_word,
  input logic                wr_fire,
  input logic [DATA_W-1:0]   wr_data,
  input rxctl_pkg::reg_sel_e wr_sel,
  input logic [1:0]          stat_sync
);
  import rxctl_pkg::*;

  logic [1:0] since_rst;
  always_ff @(posedge aclk or negedge aresetn) begin
    if (!aresetn)              since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_addr_known_r2: assert property (@(posedge aclk) disable iff (!aresetn)
    (s_awvalid |-> !$isunknown(s_awaddr)) and (s_arvalid |-> !$isunknown(s_araddr)));

  p_strb_known_r3: assert property (@(posedge aclk) disable iff (!aresetn)
    s_wvalid |-> !$isunknown(s_wstrb));

  p_bresp_okay_r4: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid |-> s_bresp == RESP_OKAY);

  p_cfg_default_r6: assert property (@(posedge aclk) disable iff (!aresetn)
    soft_rst |=> cfg_word == CFG_W'(CFG_RST));

  p_lanes_kept_r6: assert property (@(posedge aclk) disable iff (!aresetn)
    (soft_rst && !(wr_fire && wr_sel == SEL_LANES)) |=> $stable(active_lanes));

  p_shutdown_r8: assert property (@(posedge aclk) disable iff (!aresetn)
    (wr_fire && wr_sel == SEL_CTRL) |=> lane_shutdown == !$past(wr_data[0]));

  p_run_hold_r8: assert property (@(posedge aclk) disable iff (!aresetn)
    (core_en && soft_rst) |-> !lane_shutdown);

  p_sync_delay_r9: assert property (@(posedge aclk) disable iff (!aresetn)
    (since_rst >= 2'd2) |-> stat_sync[0] == $past(lbuf_full_async, 2));

  p_one_write_r10: assert property (@(posedge aclk) disable iff (!aresetn)
    s_bvalid |-> (!s_awready && !s_wready));

  p_bvalid_hold_r10: assert property (@(posedge aclk) disable iff (!aresetn)
    (s_bvalid && !s_bready) |=> s_bvalid);

  p_rd_block_r11: assert property (@(posedge aclk) disable iff (!aresetn)
    s_rvalid |-> !s_arready);

  p_rdata_hold_r11: assert property (@(posedge aclk) disable iff (!aresetn)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata) && s_rresp == RESP_OKAY));
endmodule

bind rxctl_regfile rxctl_regfile_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W), .CFG_W(CFG_W), .CFG_RST(CFG_RST)
) u_chk (
  .aclk(aclk), .aresetn(aresetn),
  .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
  .s_wstrb(s_wstrb), .s_wvalid(s_wvalid), .s_wready(s_wready),
  .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
  .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
  .lbuf_full_async(lbuf_full_async),
  .core_en(core_en), .soft_rst(soft_rst), .lane_shutdown(lane_shutdown),
  .active_lanes(active_lanes), .cfg_word(cfg_word),
  .wr_fire(wr_fire), .wr_data(wr_data), .wr_sel(wr_sel), .stat_sync(stat_sync)
);

// File: tb/sim_rxctl_regfile.sv
module sim_rxctl_regfile;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] awaddr = '0, wdata = '0, araddr = '0;
  logic [3:0]  wstrb = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
  logic        lbuf = 1'b0, spkt = 1'b0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        core_en, soft_rst, lane_shutdown;
  logic [1:0]  active_lanes;
  logic [15:0] cfg_word;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  rxctl_regfile u0 (
    .aclk(clk), .aresetn(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .lbuf_full_async(lbuf), .spkt_full_async(spkt),
    .core_en(core_en), .soft_rst(soft_rst), .lane_shutdown(lane_shutdown),
    .active_lanes(active_lanes), .cfg_word(cfg_word)
  );

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  strb;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 32'h00, 32'h0,        4'hF, 32'h1,      4'd1}, // R1
    '{1'b0, 32'h04, 32'h0,        4'hF, 32'h3,      4'd1}, // R1
    '{1'b0, 32'h08, 32'h0,        4'hF, 32'hFF,     4'd1}, // R1
    '{1'b0, 32'h10, 32'h0,        4'hF, 32'h0,      4'd9}, // R9
    '{1'b1, 32'h08, 32'hDEADBEEF, 4'hF, 32'h0,      4'd5}, // R5
    '{1'b0, 32'h08, 32'h0,        4'hF, 32'hBEEF,   4'd5}, // R5
    '{1'b1, 32'h88, 32'h1234,     4'h0, 32'h0,      4'd3}, // R3
    '{1'b0, 32'h08, 32'h0,        4'hF, 32'h1234,   4'd3}, // R3
    '{1'b0, 32'h88, 32'h0,        4'hF, 32'h1234,   4'd2}, // R2
    '{1'b1, 32'h84, 32'hFFFFFFFE, 4'h1, 32'h0,      4'd3}, // R3
    '{1'b0, 32'h04, 32'h0,        4'hF, 32'h2,      4'd5}, // R5
    '{1'b1, 32'h0C, 32'hFFFFFFFF, 4'hF, 32'h0,      4'd4}, // R4
    '{1'b0, 32'h0C, 32'h0,        4'hF, 32'h0,      4'd4}, // R4
    '{1'b0, 32'h7C, 32'h0,        4'hF, 32'h0,      4'd4}, // R4
    '{1'b0, 32'h14, 32'h0,        4'hF, 32'h0,      4'd4}, // R4
    '{1'b0, 32'h08, 32'h0,        4'hF, 32'h1234,   4'd4}, // R4
    '{1'b1, 32'h00, 32'hFFFFFFFF, 4'hF, 32'h0,      4'd6}, // R6
    '{1'b0, 32'h00, 32'h0,        4'hF, 32'h3,      4'd5}, // R5
    '{1'b0, 32'h08, 32'h0,        4'hF, 32'hFF,     4'd6}, // R6
    '{1'b0, 32'h04, 32'h0,        4'hF, 32'h2,      4'd6}, // R6
    '{1'b1, 32'h08, 32'h5555,     4'hF, 32'h0,      4'd6}, // R6
    '{1'b0, 32'h08, 32'h0,        4'hF, 32'hFF,     4'd6}, // R6
    '{1'b1, 32'h00, 32'h1,        4'hF, 32'h0,      4'd7}, // R7
    '{1'b0, 32'h00, 32'h0,        4'hF, 32'h1,      4'd7}, // R7
    '{1'b1, 32'h08, 32'h5555,     4'hF, 32'h0,      4'd7}, // R7
    '{1'b0, 32'h08, 32'h0,        4'hF, 32'h5555,   4'd7}, // R7
    '{1'b1, 32'h80, 32'h0,        4'hF, 32'h0,      4'd8}, // R8
    '{1'b0, 32'h00, 32'h0,        4'hF, 32'h0,      4'd8}  // R8
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int aw_dly, input int w_dly, input bit take_b,
                          output logic [1:0] resp);
    fork
      begin
        repeat (aw_dly) @(negedge clk);
        awaddr = a; awvalid = 1'b1;
        while (!awready) @(negedge clk);
        @(negedge clk); awvalid = 1'b0;
      end
      begin
        repeat (w_dly) @(negedge clk);
        wdata = d; wstrb = s; wvalid = 1'b1;
        while (!wready) @(negedge clk);
        @(negedge clk); wvalid = 1'b0;
      end
    join
    while (!bvalid) @(negedge clk);
    resp = bresp;
    if (take_b) begin
      bready = 1'b1;
      @(negedge clk); bready = 1'b0;
    end
  endtask

  task automatic do_read(input logic [31:0] a, input bit take_r,
                         output logic [31:0] d, output logic [1:0] resp);
    araddr = a; arvalid = 1'b1;
    while (!arready) @(negedge clk);
    @(negedge clk); arvalid = 1'b0;
    while (!rvalid) @(negedge clk);
    d = rdata; resp = rresp;
    if (take_r) begin
      rready = 1'b1;
      @(negedge clk); rready = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state at the ports
    check("R1 core_en", 32'(core_en), 32'h1);
    check("R1 soft_rst", 32'(soft_rst), 32'h0);
    check("R1 lane_shutdown", 32'(lane_shutdown), 32'h0);
    check("R1 active_lanes", 32'(active_lanes), 32'h3);
    check("R1 cfg_word", 32'(cfg_word), 32'hFF);
    check("R1 readies", {29'd0, awready, wready, arready}, 32'h7);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) begin
        do_write(VEC[i].addr, VEC[i].data, VEC[i].strb, 0, 0, 1'b1, r);
        check($sformatf("R10 bresp vec%0d (R%0d)", i, VEC[i].req), 32'(r), 32'h0);
      end else begin
        do_read(VEC[i].addr, 1'b1, d, r);
        check($sformatf("R%0d vec%0d addr 0x%02h", VEC[i].req, i, VEC[i].addr), d, VEC[i].exp);
        check($sformatf("R11 rresp vec%0d", i), 32'(r), 32'h0);
      end
    end

    // R8: run=0 shuts lanes down; hold-in-reset alone does not
    check("R8 shutdown when stopped", 32'(lane_shutdown), 32'h1);
    do_write(32'h00, 32'h3, 4'hF, 0, 0, 1'b1, r);
    check("R8 no shutdown under hold", 32'(lane_shutdown), 32'h0);
    check("R6 soft_rst port", 32'(soft_rst), 32'h1);
    check("R6 cfg_word port", 32'(cfg_word), 32'hFF);
    do_write(32'h00, 32'h1, 4'hF, 0, 0, 1'b1, r);
    check("R7 soft_rst released", 32'(soft_rst), 32'h0);

    // R9: synchroniser latency seen through reads
    lbuf = 1'b1;
    do_read(32'h10, 1'b1, d, r);
    check("R9 status old value", d, 32'h0);
    repeat (2) @(negedge clk);
    do_read(32'h10, 1'b1, d, r);
    check("R9 line-buffer flag", d, 32'h1);
    spkt = 1'b1; lbuf = 1'b0;
    repeat (3) @(negedge clk);
    do_read(32'h90, 1'b1, d, r);
    check("R9 short-packet flag", d, 32'h2);
    do_write(32'h10, 32'h0, 4'hF, 0, 0, 1'b1, r);
    do_read(32'h10, 1'b1, d, r);
    check("R9 status read-only", d, 32'h2);

    // R10: data before address, response only after both
    fork
      do_write(32'h08, 32'hA5A5, 4'hF, 4, 0, 1'b1, r);
      begin
        repeat (3) @(negedge clk);
        check("R10 no bvalid on data alone", 32'(bvalid), 32'h0);
        check("R10 data held, wready low", 32'(wready), 32'h0);
      end
    join
    do_read(32'h08, 1'b1, d, r);
    check("R10 data-first write", d, 32'hA5A5);
    do_write(32'h08, 32'h0F0F, 4'hF, 0, 3, 1'b1, r);
    do_read(32'h08, 1'b1, d, r);
    check("R10 address-first write", d, 32'h0F0F);

    // R10: pending response blocks further writes
    do_write(32'h04, 32'h1, 4'hF, 0, 0, 1'b0, r);
    repeat (3) @(negedge clk);
    check("R10 bvalid held", 32'(bvalid), 32'h1);
    check("R10 aw/w blocked", {30'd0, awready, wready}, 32'h0);
    bready = 1'b1;
    @(negedge clk); bready = 1'b0;
    check("R10 bvalid cleared", 32'(bvalid), 32'h0);
    check("R10 awready back", 32'(awready), 32'h1);

    // R11: held read response
    do_read(32'h04, 1'b0, d, r);
    repeat (3) @(negedge clk);
    check("R11 rvalid held", 32'(rvalid), 32'h1);
    check("R11 arready low", 32'(arready), 32'h0);
    check("R11 rdata stable", rdata, 32'h1);
    rready = 1'b1;
    @(negedge clk); rready = 1'b0;
    check("R11 arready back", 32'(arready), 32'h1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule